// File: doc/BRIEF.md
# Serial Direct-Form 4x4 Inverse Integer Transform

This block turns a 4x4 block of inverse-quantized coefficients into the residual block of the video-coding inverse integer transform, Y = C·X·Cᵀ. Coefficients stream in one per clock, each tagged with its row and column, straight from an inverse quantizer. No transpose store and no input buffer are needed. Each arriving coefficient is scaled by ±1, ±1/2 or ±1/4 and added into, or subtracted from, all sixteen output accumulators at once. The full residual block is ready right after the last coefficient has been absorbed.

The basis matrix C has the rows [1, 1, 1, 1/2], [1, 1/2, -1, -1], [1, -1/2, -1, 1] and [1, -1, 1, -1/2]. The weight of input X(i,j) on output Y(k,l) is C[k][i]·C[l][j]. Zero coefficients leave the input register untouched and add nothing. A coefficient at position (0,0), whether zero or not, starts a new block by clearing every accumulator. Outputs are signed fixed point with two fractional bits, so each output word equals four times the exact residual value. The word width is COEF_W+6 bits, which is wide enough that no input block can overflow it.

Top module: `itx4_serial`

## Requirements
- R1: After reset, out_done is 0 and all sixteen output words are 0.
- R2: Output word n = 4k+l, at bits [n·ACC_W +: ACC_W], equals 4·Σ C[k][i]·C[l][j]·X(i,j) as a signed integer, for a block delivered in raster order (i is the row, j is the column).
- R3: When the coefficient at (3,3) is sampled at clock edge e, out_done is 1 only between edges e+1 and e+2, and the outputs hold the final block values during that cycle.
- R4: A valid input at position (0,0) clears all accumulators before its own contribution is applied, and this also happens when its coefficient is zero.
- R5: A valid zero coefficient at any position other than (0,0) leaves every output word unchanged.
- R6: Cycles with in_valid low are ignored, whatever in_coef, in_row and in_col carry. Idle cycles may be placed between the coefficients of a block without changing its result.
- R7: Once a block has completed, the outputs hold their values until the next valid input arrives.
- R8: Blocks of full-scale coefficients (-2^(COEF_W-1) or 2^(COEF_W-1)-1) give exact results with no wrap-around.
- R9: out_done stays 0 in every cycle that does not follow the sampling of position (3,3) as set out in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Coefficient strobe |
| in_coef | input | COEF_W | Signed inverse-quantized coefficient |
| in_row | input | 2 | Row index i of the coefficient |
| in_col | input | 2 | Column index j of the coefficient |
| out_res | output | 16·ACC_W | Sixteen signed residual words, word 4k+l holds 4·Y(k,l) |
| out_done | output | 1 | One-cycle strobe: residual block complete |

## Verification
The hardest case to reach is the clear at (0,0) when that coefficient is zero. The zero-skip path must not suppress the clear, and that only shows when stale non-zero sums are left over from an earlier block. The bench therefore follows full random blocks with an all-zero block and with a block whose first coefficient alone is zero. A sweep of single-impulse blocks over all sixteen positions exposes every weight and sign on its own. Idle cycles that carry non-zero garbage at position (0,0) probe whether ignored inputs leak into the clear or the datapath.

// File: rtl/itx4_pkg.sv
package itx4_pkg;

  localparam int NSIDE = 4;
  localparam int NLANE = NSIDE * NSIDE;

  // scale chosen for one contribution, in quarter units
  typedef enum logic [1:0] {
    MAG_ONE  = 2'd0,
    MAG_TWO  = 2'd1,
    MAG_FOUR = 2'd2
  } mag_e;

  typedef struct packed {
    logic neg;
    mag_e mag;
  } wt_t;

  // twice the basis entry C[k][i]
  function automatic int basis2(input int k, input int i);
    int v;
    v = 2;
    if (i == 1) begin
      case (k)
        0: v = 2;
        1: v = 1;
        2: v = -1;
        default: v = -2;
      endcase
    end else if (i == 2) begin
      v = (k == 0 || k == 3) ? 2 : -2;
    end else if (i == 3) begin
      case (k)
        0: v = 1;
        1: v = -2;
        2: v = 2;
        default: v = -1;
      endcase
    end
    return v;
  endfunction

  function automatic wt_t weight(input int k, input int l, input int i, input int j);
    int  p;
    wt_t w;
    p     = basis2(k, i) * basis2(l, j);
    w.neg = (p < 0);
    case ((p < 0) ? -p : p)
      4:       w.mag = MAG_FOUR;
      2:       w.mag = MAG_TWO;
      default: w.mag = MAG_ONE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/itx4_front.sv
module itx4_front #(
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COEF_W-1:0] in_coef,
  input  logic [1:0]        in_row,
  input  logic [1:0]        in_col,
  output logic              stg_valid,
  output logic              stg_clr,
  output logic [1:0]        stg_row,
  output logic [1:0]        stg_col,
  output logic [COEF_W-1:0] stg_coef
);

  logic              nz, at_origin;
  logic              valid_q, clr_q, nz_q;
  logic              valid_d, clr_d, nz_d;
  logic [1:0]        row_q, col_q, row_d, col_d;
  logic [COEF_W-1:0] coef_q, coef_d;
  logic              coef_en;

  always_comb begin
    nz        = |in_coef;
    at_origin = (in_row == 2'd0) && (in_col == 2'd0);
    coef_en   = in_valid && nz;
    valid_d   = in_valid;
    clr_d     = in_valid && at_origin;
    row_d     = in_valid ? in_row : row_q;
    col_d     = in_valid ? in_col : col_q;
    nz_d      = in_valid ? nz : nz_q;
    coef_d    = coef_en ? in_coef : coef_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      clr_q   <= 1'b0;
      nz_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      valid_q <= valid_d;
      clr_q   <= clr_d;
      nz_q    <= nz_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  // input register: written only for non-zero coefficients
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= '0;
    end else if (coef_en) begin
      coef_q <= coef_d;
    end
  end

  assign stg_valid = valid_q;
  assign stg_clr   = clr_q;
  assign stg_row   = row_q;
  assign stg_col   = col_q;
  assign stg_coef  = nz_q ? coef_q : '0;

endmodule

// File: rtl/itx4_pe.sv
module itx4_pe
  import itx4_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int ACC_W  = COEF_W + 6,
  parameter int K      = 0,
  parameter int L      = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clr,
  input  logic [1:0]              row,
  input  logic [1:0]              col,
  input  logic [COEF_W-1:0]       coef,
  output logic signed [ACC_W-1:0] acc
);

  wt_t                     w;
  logic signed [ACC_W-1:0] ext, term, base, sum, acc_q, acc_d;

  always_comb begin
    w   = weight(K, L, int'(row), int'(col));
    ext = {{(ACC_W-COEF_W){coef[COEF_W-1]}}, coef};
    case (w.mag)
      MAG_FOUR: term = ext <<< 2;
      MAG_TWO:  term = ext <<< 1;
      default:  term = ext;
    endcase
    base  = clr ? '0 : acc_q;
    sum   = w.neg ? (base - term) : (base + term);
    acc_d = en ? sum : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/itx4_serial.sv
module itx4_serial
  import itx4_pkg::*;
#(
  parameter  int COEF_W = 16,
  localparam int ACC_W  = COEF_W + 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [COEF_W-1:0]      in_coef,
  input  logic [1:0]             in_row,
  input  logic [1:0]             in_col,
  output logic [NLANE*ACC_W-1:0] out_res,
  output logic                   out_done
);

  logic              stg_valid, stg_clr;
  logic [1:0]        stg_row, stg_col;
  logic [COEF_W-1:0] stg_coef;
  logic              done_q, done_d;

  itx4_front #(.COEF_W(COEF_W)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_coef   (in_coef),
    .in_row    (in_row),
    .in_col    (in_col),
    .stg_valid (stg_valid),
    .stg_clr   (stg_clr),
    .stg_row   (stg_row),
    .stg_col   (stg_col),
    .stg_coef  (stg_coef)
  );

  for (genvar k = 0; k < NSIDE; k++) begin : g_row
    for (genvar l = 0; l < NSIDE; l++) begin : g_col
      logic signed [ACC_W-1:0] acc;
      itx4_pe #(.COEF_W(COEF_W), .ACC_W(ACC_W), .K(k), .L(l)) u_pe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (stg_valid),
        .clr   (stg_clr),
        .row   (stg_row),
        .col   (stg_col),
        .coef  (stg_coef),
        .acc   (acc)
      );
      assign out_res[(k*NSIDE+l)*ACC_W +: ACC_W] = acc;
    end
  end

  always_comb begin
    done_d = stg_valid && (stg_row == 2'd3) && (stg_col == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign out_done = done_q;

endmodule

// File: rtl/itx4_serial_chk.sv
module itx4_serial_chk #(
  parameter  int COEF_W = 16,
  localparam int ACC_W  = COEF_W + 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [COEF_W-1:0]   in_coef,
  input logic [1:0]          in_row,
  input logic [1:0]          in_col,
  input logic [16*ACC_W-1:0] out_res,
  input logic                out_done
);

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row == 2'd3 && in_col == 2'd3) |=> ##1 out_done);

  // R9
  done_only_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_valid && in_row == 2'd3 && in_col == 2'd3, 2));

  // R4
  zero_origin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row == 2'd0 && in_col == 2'd0 && in_coef == '0) |=> ##1 (out_res == '0));

  // R5
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_coef == '0 && !(in_row == 2'd0 && in_col == 2'd0)) |=> ##1 $stable(out_res));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 $stable(out_res));

endmodule

bind itx4_serial itx4_serial_chk #(.COEF_W(COEF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_coef  (in_coef),
  .in_row   (in_row),
  .in_col   (in_col),
  .out_res  (out_res),
  .out_done (out_done)
);

// File: tb/itx4_serial_bench.sv
module itx4_serial_bench;

  localparam int COEF_W = 16;
  localparam int ACC_W  = COEF_W + 6;

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic [COEF_W-1:0]   in_coef;
  logic [1:0]          in_row, in_col;
  logic [16*ACC_W-1:0] out_res;
  logic                out_done;

  int n_cmp = 0;
  int n_bad = 0;
  int blk  [16];
  int expv [16];
  // twice the basis matrix, row-major
  int c2 [16] = '{2, 2, 2, 1,  2, 1, -2, -2,  2, -1, -2, 2,  2, -2, 2, -1};

  itx4_serial #(.COEF_W(COEF_W)) u_itx4_serial (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_coef  (in_coef),
    .in_row   (in_row),
    .in_col   (in_col),
    .out_res  (out_res),
    .out_done (out_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int lane(input int n);
    logic signed [ACC_W-1:0] v;
    v = out_res[n*ACC_W +: ACC_W];
    return int'(v);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compute_exp();
    for (int k = 0; k < 4; k++)
      for (int l = 0; l < 4; l++) begin
        int s = 0;
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            s += c2[k*4+i] * c2[l*4+j] * blk[i*4+j];
        expv[k*4+l] = s;
      end
  endtask

  task automatic run_block(input bit gaps, input string req);
    compute_exp();
    for (int idx = 0; idx < 16; idx++) begin
      @(negedge clk);
      chk("R9", "done during block", int'(out_done), 0);
      in_valid = 1'b1;
      in_coef  = COEF_W'(blk[idx]);
      in_row   = 2'(idx / 4);
      in_col   = 2'(idx % 4);
      if (gaps && (idx % 3 == 1)) begin
        @(negedge clk);
        // R6: garbage on an idle cycle, aimed at the origin
        in_valid = 1'b0;
        in_coef  = 16'h7abc;
        in_row   = 2'd0;
        in_col   = 2'd0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_coef  = '0;
    chk("R3", "done one cycle early", int'(out_done), 0);
    @(negedge clk);
    chk("R3", "done at completion", int'(out_done), 1);
    for (int n = 0; n < 16; n++) chk(req, $sformatf("word %0d", n), lane(n), expv[n]);
    @(negedge clk);
    chk("R3", "done width", int'(out_done), 0);
    repeat (3) @(negedge clk);
    for (int n = 0; n < 16; n++) chk("R7", $sformatf("hold word %0d", n), lane(n), expv[n]);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_coef  = '0;
    in_row   = '0;
    in_col   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "done after reset", int'(out_done), 0);
    for (int n = 0; n < 16; n++) chk("R1", $sformatf("reset word %0d", n), lane(n), 0);

    // R2: impulse sweep over every position and both signs
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 2; s++) begin
        foreach (blk[m]) blk[m] = 0;
        blk[p] = (s == 0) ? (p + 3) : -(2 * p + 5);
        run_block(1'b0, "R2");
      end

    // R2 and R6: random blocks, alternately with idle gaps
    for (int t = 0; t < 30; t++) begin
      foreach (blk[m]) blk[m] = int'($urandom_range(0, 4094)) - 2047;
      run_block(t[0], (t % 2 == 1) ? "R6" : "R2");
    end

    // R5: sparse blocks
    for (int t = 0; t < 12; t++) begin
      foreach (blk[m]) blk[m] = ($urandom_range(0, 9) < 8) ? 0 : int'($urandom_range(0, 600)) - 300;
      blk[0] = (t % 2 == 0) ? 0 : blk[0];
      run_block(t[0], "R5");
    end

    // R4: all-zero block right after a full block
    foreach (blk[m]) blk[m] = 1000 + m;
    run_block(1'b0, "R2");
    foreach (blk[m]) blk[m] = 0;
    run_block(1'b0, "R4");

    // R4: zero at the origin only, after stale sums
    foreach (blk[m]) blk[m] = -700 + 37 * m;
    run_block(1'b0, "R2");
    foreach (blk[m]) blk[m] = 5 * m - 20;
    blk[0] = 0;
    run_block(1'b1, "R4");

    // R8: full-scale blocks
    foreach (blk[m]) blk[m] = 32767;
    run_block(1'b0, "R8");
    foreach (blk[m]) blk[m] = -32768;
    run_block(1'b0, "R8");
    for (int k = 0; k < 4; k += 3) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          blk[i*4+j] = (c2[k*4+i] * c2[k*4+j] < 0) ? -32768 : 32767;
      run_block(1'b0, "R8");
    end

    summary();
    $finish;
  end

endmodule